// File: doc/BRIEF.md
# NOR Flash Toggle-Bit Completion Poller

This block runs after software or a command sequencer has started an embedded program or erase on a NOR flash. It then works out whether the device has finished. It reads the same address twice in a row over a simple read port. It compares the toggle bit (bit 6) of the two words, and it uses the time-limit flag (bit 5) to tell a device failure apart from an operation that is still running. When the status is ambiguous, it takes a second, confirming pair of reads.

The caller gives a start pulse with the address to poll and a timeout limit. The limit is counted in ticks of an external tick-enable input. The block issues read pairs until it reaches a verdict: success, device error or timeout. It reports the verdict as a two-bit code together with a one-cycle done pulse. The code stays on the output until the next verdict replaces it.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset, `done`, `busy` and `rd_req` are low and `result` is 2'b00.
- R2: A start pulse accepted while idle latches `poll_addr` and `timeout_lim` and raises `busy`. Every read is requested on `rd_addr` with the latched address. `rd_req` is a one-cycle pulse, and the next read is requested only after `rd_valid` returns the previous word.
- R3: If bit 6 (mask 0x40) is equal in both words of a pair, the block finishes with `result` 2'b01 (success).
- R4: If bit 6 differs within a pair and bit 5 (mask 0x20) of the first word is clear, the block polls another pair. Bit 5 of the second word has no effect.
- R5: If bit 6 differs and bit 5 of the first word is set, the block does not fail at once. It takes one confirming pair.
- R6: On the confirming pair, equal bit 6 gives success. Bit 6 differing with bit 5 of its first word set gives `result` 2'b10 (device error). Bit 6 differing with that bit 5 clear drops the confirmation and polling goes on.
- R7: A timeout limit of zero gives `result` 2'b11 (timeout) without any read.
- R8: The tick counter is cleared when start is accepted. It advances only on cycles with `tick_en` high. Before each read pair, a count above the limit ends the run with `result` 2'b11.
- R9: An all-ones timeout limit disables the timeout check.
- R10: `done` is high for exactly one cycle per run, together with a non-zero `result`. `result` changes only when `done` is high.
- R11: A start pulse while `busy` is high is ignored. The run in progress keeps its address and limit and gives exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start polling (taken only while idle) |
| poll_addr | input | ADDR_W | Address to poll |
| timeout_lim | input | TIMER_W | Timeout limit in ticks; 0 = immediate timeout, all ones = no timeout |
| tick_en | input | 1 | Advances the elapsed-tick counter |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Returned read word |
| rd_valid | input | 1 | `rd_data` is valid this cycle |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle verdict strobe |
| result | output | 2 | 01 success, 10 device error, 11 timeout, 00 none yet |

## Verification
The ports show a corrupted internal state quickly. A lost or stale confirmation flag appears within one read pair, as a wrong read count or a device error where success was due. A wrong latched address appears on `rd_addr` with the very next request. A counter that is not cleared, or that counts without `tick_en`, turns a long but healthy run into an early timeout at the next check between pairs. The bench therefore checks the verdict, the exact number of reads and the address of each read for every scripted status sequence.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  // Status word bit positions decoded by the poller
  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_OK      = 2'b01,
    RES_DEVERR  = 2'b10,
    RES_TIMEOUT = 2'b11
  } poll_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT1,
    ST_WAIT2,
    ST_EVAL
  } poll_state_e;

endpackage

// File: rtl/nor_tick_timer.sv
module nor_tick_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic               tick_en,
  input  logic [TIMER_W-1:0] limit,
  output logic               expired
);

  localparam logic [TIMER_W-1:0] CNT_MAX = {TIMER_W{1'b1}};

  logic [TIMER_W-1:0] count_q;
  logic               forever_w;
  logic               zero_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (run && tick_en && (count_q != CNT_MAX)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign forever_w = (limit == CNT_MAX);
  assign zero_w    = (limit == '0);
  assign expired   = zero_w || (!forever_w && (count_q > limit));

  // Counter saturates rather than wrapping (R8)
  assert_cnt_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_MAX && !clear) |=> (count_q == CNT_MAX));

  // Counter never moves without a tick (R8)
  assert_cnt_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clear) |=> $stable(count_q));

endmodule

// File: rtl/nor_pair_judge.sv
module nor_pair_judge
  import nor_poll_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  output logic              settled,
  output logic              limit_flag
);

  logic unused_bits;

  // Toggle bit stopped moving: operation finished
  assign settled    = (word_a[TOGGLE_BIT] == word_b[TOGGLE_BIT]);
  // Time-limit flag is taken from the first word of the pair only
  assign limit_flag = word_a[LIMIT_BIT];

  assign unused_bits = ^{word_a, word_b};

endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  poll_addr,
  input  logic [TIMER_W-1:0] timeout_lim,
  input  logic               tick_en,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               rd_valid,
  output logic               busy,
  output logic               done,
  output logic [1:0]         result
);

  poll_state_e        state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [TIMER_W-1:0] limit_q;
  logic [DATA_W-1:0]  word0_q;
  logic [DATA_W-1:0]  word1_q;
  logic               confirm_q;
  logic               req_q;
  logic               done_q;
  poll_result_e       result_q;

  logic               accept_w;
  logic               expired_w;
  logic               settled_w;
  logic               limit_flag_w;

  assign accept_w = (state_q == ST_IDLE) && start;

  nor_tick_timer #(.TIMER_W(TIMER_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept_w),
    .run     (state_q != ST_IDLE),
    .tick_en (tick_en),
    .limit   (limit_q),
    .expired (expired_w)
  );

  nor_pair_judge #(.DATA_W(DATA_W)) judge_i (
    .word_a     (word0_q),
    .word_b     (word1_q),
    .settled    (settled_w),
    .limit_flag (limit_flag_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      limit_q   <= '0;
      word0_q   <= '0;
      word1_q   <= '0;
      confirm_q <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      result_q  <= RES_NONE;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= poll_addr;
            limit_q   <= timeout_lim;
            confirm_q <= 1'b0;
            state_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (expired_w) begin
            result_q <= RES_TIMEOUT;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            req_q   <= 1'b1;
            state_q <= ST_WAIT1;
          end
        end
        ST_WAIT1: begin
          if (rd_valid) begin
            word0_q <= rd_data;
            req_q   <= 1'b1;
            state_q <= ST_WAIT2;
          end
        end
        ST_WAIT2: begin
          if (rd_valid) begin
            word1_q <= rd_data;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (settled_w) begin
            result_q <= RES_OK;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (limit_flag_w && confirm_q) begin
            result_q <= RES_DEVERR;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            confirm_q <= limit_flag_w;
            state_q   <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign result  = result_q;

  // Requests are only made during a run (R2)
  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // Request is a single-cycle pulse (R2)
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // Zero limit ends the run before any read (R7)
  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && limit_q == '0) |=> (done && result == RES_TIMEOUT && !rd_req));

  // Done is one cycle wide and carries a real verdict (R10)
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_code_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != RES_NONE));
  assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  // Start during a run leaves the address alone (R11)
  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rd_addr));

endmodule

// File: tb/nor_toggle_poller_tb.sv
module nor_toggle_poller_tb_top;

  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int LAT = 2;
  localparam int NV  = 7;

  // Each vector: up to eight status bytes (first read in the top byte),
  // expected read count and expected result code.
  localparam logic [63:0] V_RD [NV] = '{
    64'h4040_0000_0000_0000,
    64'h4000_4444_0000_0000,
    64'h6020_6020_0000_0000,
    64'h6020_2020_0000_0000,
    64'h6020_0040_6020_4040,
    64'h0060_0060_4040_0000,
    64'h7F3F_3F7F_0000_0000
  };
  localparam int V_N [NV] = '{2, 4, 4, 4, 8, 6, 4};
  localparam logic [1:0] V_RES [NV] = '{2'b01, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10};
  localparam string V_REQ [NV] = '{"R3", "R4", "R5", "R6", "R6", "R4", "R6"};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [TW-1:0] timeout_lim = '0;
  logic          tick_en = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          rd_valid = 1'b0;
  logic          busy;
  logic          done;
  logic [1:0]    result;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [DW-1:0] script [16];
  int            idx = 0;
  int            n_reads = 0;
  int            countdown = 0;
  logic [AW-1:0] exp_addr = '0;
  int            addr_errs = 0;
  int            n_done = 0;

  always #5 clk = ~clk;

  nor_toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .TIMER_W(TW)) dut_i (
    .clk, .rst, .start, .poll_addr, .timeout_lim, .tick_en,
    .rd_req, .rd_addr, .rd_data, .rd_valid, .busy, .done, .result
  );

  // Read responder: fixed latency, words from the script
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (done) n_done++;
      rd_valid = 1'b0;
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          rd_valid = 1'b1;
          rd_data  = (idx < 16) ? script[idx] : 16'h0000;
          idx++;
          n_reads++;
        end
      end
      if (rd_req) begin
        countdown = LAT;
        if (rd_addr !== exp_addr) addr_errs++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_script();
    for (int i = 0; i < 16; i++) script[i] = 16'h0000;
    idx = 0; n_reads = 0; addr_errs = 0; n_done = 0;
  endtask

  task automatic kick(input logic [AW-1:0] a, input logic [TW-1:0] lim);
    exp_addr    = a;
    poll_addr   = a;
    timeout_lim = lim;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  // Wait for done; returns with the result visible at a negedge
  task automatic wait_done(output bit got);
    int w = 0;
    got = 1'b0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    got = done;
  endtask

  task automatic finish_run(input string req, input logic [1:0] exp_res, input int exp_n);
    bit got;
    wait_done(got);
    check(got, req, got, 1);
    check(result == exp_res, req, result, exp_res);
    check(n_reads == exp_n, req, n_reads, exp_n);
    check(addr_errs == 0, "R2", addr_errs, 0);
    @(negedge clk);
    check(!done && result == exp_res && !busy, "R10", {done, result}, {1'b0, exp_res});
  endtask

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!done && !busy && !rd_req && result == 2'b00, "R1",
          {done, busy, rd_req, result}, 0);

    // Table-driven status sequences, no ticks
    for (int v = 0; v < NV; v++) begin
      clear_script();
      for (int i = 0; i < 8; i++) script[i] = {8'h00, V_RD[v][63-8*i -: 8]};
      kick(24'h10_0000 + 24'(v * 16'h0102), 16'd50);
      check(busy, "R2", busy, 1);
      finish_run(V_REQ[v], V_RES[v], V_N[v]);
    end

    // R7: zero limit, immediate timeout, no reads
    clear_script();
    kick(24'hAB_CDEF, 16'd0);
    finish_run("R7", 2'b11, 0);

    // R8: ticks every cycle, limit 3, device keeps toggling
    clear_script();
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 16'h0000 : 16'h0040;
    tick_en = 1'b1;
    kick(24'h00_0F00, 16'd3);
    finish_run("R8", 2'b11, 2);

    // R8: without tick_en a small limit is never exceeded
    clear_script();
    for (int i = 0; i < 6; i++) script[i] = (i % 2 == 0) ? 16'h0000 : 16'h0040;
    script[6] = 16'h0040; script[7] = 16'h0040;
    tick_en = 1'b0;
    kick(24'h00_0F10, 16'd1);
    finish_run("R8", 2'b01, 8);

    // R9: all-ones limit with ticks running over a long poll
    clear_script();
    for (int i = 0; i < 14; i++) script[i] = (i % 2 == 0) ? 16'h0000 : 16'h0040;
    script[14] = 16'h0000; script[15] = 16'h0000;
    tick_en = 1'b1;
    kick(24'h00_0F20, 16'hFFFF);
    finish_run("R9", 2'b01, 16);
    tick_en = 1'b0;

    // R11: start during a run is ignored
    clear_script();
    script[0] = 16'h0000; script[1] = 16'h0040;
    script[2] = 16'h0000; script[3] = 16'h0040;
    script[4] = 16'h0040; script[5] = 16'h0040;
    kick(24'h33_4455, 16'd100);
    repeat (4) @(negedge clk);
    poll_addr   = 24'h77_0000;
    timeout_lim = 16'd0;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
    finish_run("R11", 2'b01, 6);
    repeat (20) @(negedge clk);
    check(n_done == 1 && !busy, "R11", n_done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule